// File: doc/BRIEF.md
# Four-Mode Serial Transmitter

This block drives the outgoing line of a four-mode serial port. Software selects the frame format with a two-bit mode value and starts a frame by writing a byte. In the synchronous shift mode the byte leaves on the data line alongside a generated shift clock. In the three asynchronous modes the line carries a framed character. Two of those modes append a ninth bit whose value comes from a control input.

A sticky completion flag tells software that the transmitter can take the next byte. In the shift mode it rises when the eighth bit time ends. In the asynchronous modes it rises when the stop bit begins, so software can prepare the next byte while the stop bit is still on the line. The bit rate is built inside the block for modes 00 and 10. For modes 01 and 11 it comes from an external tick pulse.

The controller is a state machine with the states IDLE, START, DATA, NINTH, STOP and SHIFT:
- IDLE→START on an accepted write in modes 01, 10 and 11.
- IDLE→SHIFT on an accepted write in mode 00.
- START→DATA at the end of the start bit.
- DATA→NINTH after the eighth data bit in modes 10 and 11.
- DATA→STOP after the eighth data bit in mode 01.
- NINTH→STOP at the end of the ninth bit.
- STOP→IDLE at the end of the stop bit.
- SHIFT→IDLE after the eighth bit time.

Top module: `mm_serial_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` and `shift_clk` are high and `tx_flag` is low until a frame sets it.
- R2: Modes 01, 10 and 11 send one low start bit, then the 8 data bits LSB first, then one high stop bit. Modes 10 and 11 insert, before the stop bit, a ninth bit equal to `ninth_bit` as sampled at the write. Mode 01 sends no ninth bit.
- R3: Mode 00 puts the 8 data bits on `txd` LSB first. In every bit time `shift_clk` is low for the first half and high for the second half, and `txd` changes only at the start of a bit time, while `shift_clk` is low.
- R4: In mode 00 one bit time is 12 `clk` cycles, or 6 when `fast_clk` is high.
- R5: In mode 10 one bit time is 64 `clk` cycles, or 32 with `dbl_rate` high. A high `fast_clk` halves either value, giving 32 or 16.
- R6: In modes 01 and 11 every bit, the start bit included, ends at a `bit_tick` pulse. A frame begins in the cycle after the accepting write.
- R7: `tx_flag` rises on the same clock edge on which the stop bit begins (modes 01, 10, 11), or on which the eighth bit time ends (mode 00).
- R8: `tx_flag` stays high until `flag_clr` is pulsed. When a set and `flag_clr` fall in the same cycle, the set wins.
- R9: A write while a frame is in progress is ignored. The current frame completes unchanged, including its data, ninth bit and mode.
- R10: The stop bit lasts one bit time. After it, and after the eighth bit time in mode 00, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Frame format: 00 shift, 01 8-bit async, 10 9-bit fixed rate, 11 9-bit tick rate |
| ninth_bit | input | 1 | Value of the ninth bit in modes 10 and 11 |
| fast_clk | input | 1 | Double-speed clock mode (halves internal bit times) |
| dbl_rate | input | 1 | Rate doubling for mode 10 |
| bit_tick | input | 1 | One-cycle bit boundary pulse for modes 01 and 11 |
| wr_strobe | input | 1 | Data write; starts a frame when idle |
| wr_data | input | 8 | Byte to send |
| flag_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial data line |
| shift_clk | output | 1 | Shift clock for mode 00 (high when unused) |
| tx_flag | output | 1 | Sticky completion flag |

## Verification
Some properties are checked on every cycle:
- The line and the clock idle high.
- The completion flag only falls after a clear and only rises while a frame is active.
- A frame opens with a low start bit, or in mode 00 with a low shift clock.
- Data never moves on a rising shift clock.

Bit order, the ninth-bit value, the exact bit-time lengths for each rate selection, the flag's exact edge, and the frame surviving a mid-frame write with altered data and ninth bit are shown by the directed scenarios. Those scenarios sample every bit at its centre.

// File: rtl/mmtx_pkg.sv
package mmtx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_NINTH,
        TX_STOP,
        TX_SHIFT
    } tx_state_e;

    localparam logic [1:0] MODE_SHIFT  = 2'b00;
    localparam logic [1:0] MODE_ASYNC8 = 2'b01;
    localparam logic [1:0] MODE_FIX9   = 2'b10;
    localparam logic [1:0] MODE_VAR9   = 2'b11;

endpackage

// File: rtl/mmtx_rate.sv
module mmtx_rate
    import mmtx_pkg::*;
#(
    parameter int M0_DIV = 12,
    parameter int M2_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic [1:0] mode_q,
    input  logic       fast_clk,
    input  logic       dbl_rate,
    input  logic       bit_tick,
    output logic       bit_end,
    output logic       phase_hi
);

    localparam int MAXDIV = (M0_DIV > M2_DIV) ? M0_DIV : M2_DIV;
    localparam int CW     = $clog2(MAXDIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;
    logic          internal;

    always_comb begin
        unique case (mode_q)
            MODE_SHIFT: period = fast_clk ? CW'(M0_DIV / 2) : CW'(M0_DIV);
            MODE_FIX9:  period = CW'(M2_DIV >> (int'(fast_clk) + int'(dbl_rate)));
            default:    period = CW'(M0_DIV);
        endcase
    end

    assign internal = (mode_q == MODE_SHIFT) || (mode_q == MODE_FIX9);
    assign bit_end  = busy && (internal ? (cnt == period - CW'(1)) : bit_tick);
    assign phase_hi = cnt >= (period >> 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!busy || bit_end || !internal) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/mmtx_shifter.sv
module mmtx_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] din,
    output logic          lsb
);

    logic [DW-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= din;
        end else if (shift) begin
            sh <= {1'b0, sh[DW-1:1]};
        end
    end

    assign lsb = sh[0];

endmodule

// File: rtl/mmtx_ctrl.sv
module mmtx_ctrl
    import mmtx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ninth_in,
    input  logic       wr_strobe,
    input  logic       bit_end,
    input  logic       phase_hi,
    input  logic       data_lsb,
    output logic       busy,
    output logic [1:0] mode_q,
    output logic       load,
    output logic       shift,
    output logic       done_evt,
    output logic       txd,
    output logic       shift_clk
);

    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    tx_state_e     state, nxt;
    logic [BW-1:0] bcnt;
    logic          ninth_q;
    logic          last_bit;

    assign last_bit = (bcnt == BW'(DW - 1));
    assign busy     = (state != TX_IDLE);

    // State register, bit counter and frame latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            bcnt    <= '0;
            mode_q  <= MODE_SHIFT;
            ninth_q <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                bcnt    <= '0;
                mode_q  <= mode;
                ninth_q <= ninth_in;
            end else if (shift) begin
                bcnt <= last_bit ? '0 : bcnt + BW'(1);
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: begin
                if (wr_strobe) nxt = (mode == MODE_SHIFT) ? TX_SHIFT : TX_START;
            end
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA: begin
                if (bit_end && last_bit) nxt = mode_q[1] ? TX_NINTH : TX_STOP;
            end
            TX_NINTH: if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
            TX_SHIFT: if (bit_end && last_bit) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load      = (state == TX_IDLE) && wr_strobe;
        shift     = bit_end && ((state == TX_DATA) || (state == TX_SHIFT));
        done_evt  = 1'b0;
        txd       = 1'b1;
        shift_clk = 1'b1;
        unique case (state)
            TX_IDLE:  ;
            TX_START: txd = 1'b0;
            TX_DATA: begin
                txd      = data_lsb;
                done_evt = bit_end && last_bit && !mode_q[1];
            end
            TX_NINTH: begin
                txd      = ninth_q;
                done_evt = bit_end;
            end
            TX_STOP:  ;
            TX_SHIFT: begin
                txd       = data_lsb;
                shift_clk = phase_hi;
                done_evt  = bit_end && last_bit;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/mm_serial_tx.sv
module mm_serial_tx
    import mmtx_pkg::*;
#(
    parameter int DW     = 8,
    parameter int M0_DIV = 12,
    parameter int M2_DIV = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          ninth_bit,
    input  logic          fast_clk,
    input  logic          dbl_rate,
    input  logic          bit_tick,
    input  logic          wr_strobe,
    input  logic [DW-1:0] wr_data,
    input  logic          flag_clr,
    output logic          txd,
    output logic          shift_clk,
    output logic          tx_flag
);

    logic       busy;
    logic [1:0] mode_q;
    logic       load, shift, done_evt;
    logic       bit_end, phase_hi, data_lsb;

    mmtx_rate #(.M0_DIV(M0_DIV), .M2_DIV(M2_DIV)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .mode_q   (mode_q),
        .fast_clk (fast_clk),
        .dbl_rate (dbl_rate),
        .bit_tick (bit_tick),
        .bit_end  (bit_end),
        .phase_hi (phase_hi)
    );

    mmtx_shifter #(.DW(DW)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .din   (wr_data),
        .lsb   (data_lsb)
    );

    mmtx_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ninth_in  (ninth_bit),
        .wr_strobe (wr_strobe),
        .bit_end   (bit_end),
        .phase_hi  (phase_hi),
        .data_lsb  (data_lsb),
        .busy      (busy),
        .mode_q    (mode_q),
        .load      (load),
        .shift     (shift),
        .done_evt  (done_evt),
        .txd       (txd),
        .shift_clk (shift_clk)
    );

    // Sticky completion flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
        end else if (done_evt) begin
            tx_flag <= 1'b1;
        end else if (flag_clr) begin
            tx_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/mmtx_checker.sv
module mmtx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       flag_clr,
    input logic       txd,
    input logic       shift_clk,
    input logic       tx_flag,
    input logic       busy
);

    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && shift_clk));

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && ($past(mode) != 2'b00)) |-> !txd);

    assert_clk_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && ($past(mode) == 2'b00)) |-> !shift_clk);

    assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk) |-> $stable(txd));

    assert_clk_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_clk |-> busy);

    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) |-> $past(busy));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_flag) && !tx_flag) |-> $past(flag_clr));

endmodule

bind mm_serial_tx mmtx_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .flag_clr  (flag_clr),
    .txd       (txd),
    .shift_clk (shift_clk),
    .tx_flag   (tx_flag),
    .busy      (busy)
);

// File: tb/test_mm_serial_tx.sv
`timescale 1ns/1ps
module test_mm_serial_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       ninth_bit = 1'b0;
    logic       fast_clk = 1'b0;
    logic       dbl_rate = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       flag_clr = 1'b0;
    logic       txd, shift_clk, tx_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mm_serial_tx i_mm_serial_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ninth_bit (ninth_bit),
        .fast_clk  (fast_clk),
        .dbl_rate  (dbl_rate),
        .bit_tick  (bit_tick),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .flag_clr  (flag_clr),
        .txd       (txd),
        .shift_clk (shift_clk),
        .tx_flag   (tx_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // One frame; p = expected bit time in cycles, poke_c = cycle of an ignored write,
    // clr_c = cycle on which flag_clr collides with the flag set edge (0 = none)
    task automatic run_frame(input logic [1:0] md, input bit fst, input bit dbl,
                             input logic [7:0] d, input bit n9, input int p,
                             input int poke_c, input int clr_c, input string tag);
        logic [10:0] bits;
        int nb;
        int flag_off;
        bit tickmode;
        tickmode = md[0];
        if (md == 2'b00) begin
            nb = 8;
            bits = {3'b000, d};
            flag_off = 8 * p;
        end else if (md == 2'b01) begin
            nb = 10;
            bits = {1'b0, 1'b1, d, 1'b0};
            flag_off = 9 * p;
        end else begin
            nb = 11;
            bits = {1'b1, n9, d, 1'b0};
            flag_off = 10 * p;
        end
        @(negedge clk);
        mode = md; fast_clk = fst; dbl_rate = dbl;
        wr_data = d; ninth_bit = n9; wr_strobe = 1'b1;
        @(posedge clk);
        for (int c = 1; c <= nb * p + 2; c++) begin
            int j, idx, ph;
            @(negedge clk);
            j = c - 1; idx = j / p; ph = j % p;
            if (idx < nb && ph == p / 2)
                check(txd == bits[idx], {tag, " bit value"}, txd, bits[idx]);
            if (md == 2'b00 && idx < nb) begin
                if (ph == 0) begin
                    check(shift_clk == 1'b0, {tag, " R3 clk low at bit start"}, shift_clk, 0);
                    check(txd == bits[idx], {tag, " R3 data set while clk low"}, txd, bits[idx]);
                end
                if (ph == p / 2)
                    check(shift_clk == 1'b1, {tag, " R3 clk high mid-bit"}, shift_clk, 1);
                if (ph == p / 2 - 1)
                    check(shift_clk == 1'b0, {tag, " R3 clk low first half"}, shift_clk, 0);
            end
            if (j == flag_off - 1)
                check(tx_flag == 1'b0, {tag, " R7 flag not early"}, tx_flag, 0);
            if (j == flag_off)
                check(tx_flag == 1'b1, {tag, " R7 flag at edge"}, tx_flag, 1);
            if (j == nb * p) begin
                check(txd == 1'b1, {tag, " R10 idle line after frame"}, txd, 1);
                check(shift_clk == 1'b1, {tag, " R10 idle clock after frame"}, shift_clk, 1);
            end
            if (c == poke_c) begin
                wr_strobe = 1'b1; wr_data = ~d; ninth_bit = ~n9;
            end else begin
                wr_strobe = 1'b0; wr_data = d; ninth_bit = n9;
            end
            bit_tick = tickmode && (c % p == 0);
            flag_clr = (c == clr_c);
        end
        @(negedge clk);
        bit_tick = 1'b0; flag_clr = 1'b0; wr_strobe = 1'b0;
    endtask

    task automatic t_reset();
        check(txd == 1'b1, "R1 reset txd", txd, 1);
        check(shift_clk == 1'b1, "R1 reset shift_clk", shift_clk, 1);
        check(tx_flag == 1'b0, "R1 reset flag", tx_flag, 0);
    endtask

    task automatic t_mode0();
        clear_flag();
        run_frame(2'b00, 1'b0, 1'b0, 8'hA5, 1'b0, 12, 0, 0, "R3 R4 mode0 slow");
        clear_flag();
        run_frame(2'b00, 1'b1, 1'b0, 8'h3C, 1'b0, 6, 0, 0, "R3 R4 mode0 fast");
    endtask

    task automatic t_async8();
        clear_flag();
        run_frame(2'b01, 1'b0, 1'b0, 8'h6B, 1'b1, 8, 0, 0, "R2 R6 mode1");
    endtask

    task automatic t_mode2();
        clear_flag();
        run_frame(2'b10, 1'b0, 1'b0, 8'hC3, 1'b1, 64, 0, 0, "R2 R5 mode2 /64");
        clear_flag();
        run_frame(2'b10, 1'b0, 1'b1, 8'h1E, 1'b0, 32, 0, 0, "R2 R5 mode2 /32");
        clear_flag();
        run_frame(2'b10, 1'b1, 1'b1, 8'h81, 1'b1, 16, 0, 0, "R2 R5 mode2 fast /16");
    endtask

    task automatic t_mode3();
        clear_flag();
        run_frame(2'b11, 1'b0, 1'b0, 8'h55, 1'b0, 8, 0, 0, "R2 R6 mode3 n9=0");
        clear_flag();
        run_frame(2'b11, 1'b0, 1'b0, 8'hF0, 1'b1, 10, 0, 0, "R2 R6 mode3 n9=1");
    endtask

    task automatic t_busy_write();
        clear_flag();
        run_frame(2'b11, 1'b0, 1'b0, 8'h96, 1'b1, 8, 25, 0, "R9 mode3 write ignored");
        clear_flag();
        run_frame(2'b00, 1'b0, 1'b0, 8'h2D, 1'b0, 12, 30, 0, "R9 mode0 write ignored");
    endtask

    task automatic t_flag();
        clear_flag();
        // flag_clr collides with the set edge at cycle 9*8 of a mode 01 frame
        run_frame(2'b01, 1'b0, 1'b0, 8'h0F, 1'b0, 8, 0, 72, "R8 set beats clear");
        @(negedge clk);
        check(tx_flag == 1'b1, "R8 flag held after collision", tx_flag, 1);
        repeat (40) @(negedge clk);
        check(tx_flag == 1'b1, "R8 flag sticky while idle", tx_flag, 1);
        clear_flag();
        check(tx_flag == 1'b0, "R8 flag cleared", tx_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_async8();
        t_mode2();
        t_mode3();
        t_busy_write();
        t_flag();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule